// File: doc/BRIEF.md
# Burst Quadword Address Sequencer

This block sits on the system side of a processor bus. It turns one burst request into the four quadword addresses that fill a 32-byte cache line. The processor supplies only the address of the first quadword, as bits 31:3; bits 2:0 do not exist on the bus. The block creates the other three addresses in an interleaved order. The low address bits 4:3 of each beat are the starting quadword offset XORed with the beat count. For example, a start at line offset 10h visits 10h, 18h, 00h, 08h.

A one-cycle start pulse, taken only while the block is idle, captures three things: the address, a read/writeback indication and the active-low byte enables. The current beat is presented as a valid/ready stream. `qw_valid_o` stays high for the whole burst. A beat completes on a cycle where `qw_valid_o` and `beat_rdy_i` are both high. While `beat_rdy_i` is low the beat is held, and the address, beat index and last flag stay unchanged. There is no limit on how long a beat may wait.

For reads, the byte enables only pick bytes inside the first quadword and do not change the order of beats. A writeback must start on a line boundary with all eight bytes enabled. If it does not, a one-cycle error pulse is raised, and the sequence still runs from offset 00h. For inquire cycles, a separate path drives the 32-byte line address with bits 4:3 forced to a valid 00b.

Top module: `burst_qw_seq`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `qw_valid_o`, `last_o` and `err_o` are 0 and `beat_idx_o` is 0.
- R2: A `start_i` pulse seen at a clock edge while idle makes `qw_valid_o` 1 from the next cycle, with `beat_idx_o` = 0. For a read (`wb_i`=0), `qw_addr_o` equals `start_addr_i`.
- R3: On beat n (n = 0..3), `qw_addr_o[31:5]` equals the captured line and `qw_addr_o[4:3]` equals the starting offset (bits 4:3) XOR n.
- R4: A beat advances only on a cycle where `qw_valid_o` and `beat_rdy_i` are both 1. When `beat_rdy_i` is 0, `qw_addr_o`, `beat_idx_o` and `last_o` hold their values.
- R5: `last_o` is 1 exactly while `qw_valid_o` is 1 and `beat_idx_o` = 3. After the handshake of that beat, `qw_valid_o` is 0 on the next cycle.
- R6: A `start_i` pulse while `qw_valid_o` is 1 is ignored: the address, beat index and remaining beat count are unchanged.
- R7: For a read, any value of `be_n_i` leaves the address sequence unchanged and raises no error.
- R8: For a writeback (`wb_i`=1), the beats use offsets 00b, 01b, 10b, 11b in bits 4:3, whatever the starting address bits 4:3 are.
- R9: On an accepted writeback start, `err_o` is 1 for exactly the next cycle when start bits 4:3 are not 00b or `be_n_i` is not 00h. It stays 0 for a clean writeback.
- R10: `inq_addr_o` equals {`inq_line_i`, 2'b00} while `inq_en_i` is 1, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle burst start pulse |
| start_addr_i | input | 29 | First quadword address, bits 31:3 |
| wb_i | input | 1 | 1 = writeback burst, 0 = read burst |
| be_n_i | input | 8 | Active-low byte enables of the first quadword |
| beat_rdy_i | input | 1 | Ready for the current beat (data moved) |
| qw_valid_o | output | 1 | A burst beat is presented |
| qw_addr_o | output | 29 | Current quadword address, bits 31:3 |
| beat_idx_o | output | 2 | Index of the current beat |
| last_o | output | 1 | Current beat is the fourth |
| err_o | output | 1 | One-cycle writeback protocol error |
| inq_en_i | input | 1 | Inquire cycle in progress |
| inq_line_i | input | 27 | Inquire line address, bits 31:5 |
| inq_addr_o | output | 29 | Inquire address with bits 4:3 driven to 00b |

## Verification
Read bursts are tried from every starting offset, 00h, 08h, 10h and 18h. These runs tell the interleaved XOR order apart from a linear increment and from a fixed order. Bursts with ready held low between beats show whether the hold under back-pressure works or whether a beat is skipped or repeated. Writebacks are tried three ways: clean, with a misaligned start, and with partial byte enables. These show the forced 00h start and both error causes. A start pulse inside a burst, and reads with sparse byte enables, show that those inputs leave the sequence alone.

// File: rtl/bqs_pkg.sv
package bqs_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} bqs_state_e;
endpackage

// File: rtl/bqs_start_chk.sv
module bqs_start_chk #(
  parameter int ADDR_W = 29,
  parameter int OFF_W  = 2,
  parameter int BE_W   = 8
) (
  input  logic [OFF_W-1:0] start_off_i,
  input  logic             wb_i,
  input  logic [BE_W-1:0]  be_n_i,
  output logic [OFF_W-1:0] eff_off_o,
  output logic             bad_o
);
  localparam int LINE_W = ADDR_W - OFF_W;

  // Writebacks always begin at the line boundary.
  always_comb begin
    eff_off_o = wb_i ? '0 : start_off_i;
    bad_o     = wb_i && ((start_off_i != '0) || (be_n_i != '0)) && (LINE_W > 0);
  end
endmodule

// File: rtl/bqs_beat_ctr.sv
module bqs_beat_ctr
  import bqs_pkg::*;
#(
  parameter int OFF_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             rdy_i,
  output logic             accept_o,
  output logic             valid_o,
  output logic [OFF_W-1:0] beat_o,
  output logic             last_o
);
  localparam logic [OFF_W-1:0] LAST_BEAT = '1;

  bqs_state_e       state_q;
  logic [OFF_W-1:0] beat_q;
  logic             fire;

  assign accept_o = start_i && (state_q == ST_IDLE);
  assign valid_o  = (state_q == ST_RUN);
  assign fire     = valid_o && rdy_i;
  assign beat_o   = beat_q;
  assign last_o   = valid_o && (beat_q == LAST_BEAT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
    end else if (accept_o) begin
      state_q <= ST_RUN;
      beat_q  <= '0;
    end else if (fire) begin
      if (beat_q == LAST_BEAT) begin
        state_q <= ST_IDLE;
        beat_q  <= '0;
      end else begin
        beat_q <= beat_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bqs_addr_gen.sv
module bqs_addr_gen #(
  parameter int ADDR_W = 29,
  parameter int OFF_W  = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load_i,
  input  logic [ADDR_W-OFF_W-1:0]  line_i,
  input  logic [OFF_W-1:0]         off_i,
  input  logic [OFF_W-1:0]         beat_i,
  output logic [ADDR_W-1:0]        addr_o
);
  localparam int LINE_W = ADDR_W - OFF_W;

  logic [LINE_W-1:0] line_q;
  logic [OFF_W-1:0]  off_q;
  logic [OFF_W-1:0]  lo;

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q <= '0;
      off_q  <= '0;
    end else if (load_i) begin
      line_q <= line_i;
      off_q  <= off_i;
    end
  end

  // Interleaved order: each low bit toggles with the matching beat bit.
  for (genvar g = 0; g < OFF_W; g++) begin : g_ilv
    assign lo[g] = off_q[g] ^ beat_i[g];
  end

  assign addr_o = {line_q, lo};
endmodule

// File: rtl/burst_qw_seq.sv
module burst_qw_seq #(
  parameter int ADDR_W = 29,
  parameter int OFF_W  = 2,
  parameter int BE_W   = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start_i,
  input  logic [ADDR_W-1:0]       start_addr_i,
  input  logic                    wb_i,
  input  logic [BE_W-1:0]         be_n_i,
  input  logic                    beat_rdy_i,
  output logic                    qw_valid_o,
  output logic [ADDR_W-1:0]       qw_addr_o,
  output logic [OFF_W-1:0]        beat_idx_o,
  output logic                    last_o,
  output logic                    err_o,
  input  logic                    inq_en_i,
  input  logic [ADDR_W-OFF_W-1:0] inq_line_i,
  output logic [ADDR_W-1:0]       inq_addr_o
);
  localparam int LINE_W = ADDR_W - OFF_W;

  logic             accept;
  logic [OFF_W-1:0] eff_off;
  logic             bad;
  logic             err_q;

  bqs_start_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .BE_W(BE_W)) u_chk (
    .start_off_i (start_addr_i[OFF_W-1:0]),
    .wb_i        (wb_i),
    .be_n_i      (be_n_i),
    .eff_off_o   (eff_off),
    .bad_o       (bad)
  );

  bqs_beat_ctr #(.OFF_W(OFF_W)) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .rdy_i    (beat_rdy_i),
    .accept_o (accept),
    .valid_o  (qw_valid_o),
    .beat_o   (beat_idx_o),
    .last_o   (last_o)
  );

  bqs_addr_gen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_gen (
    .clk    (clk),
    .rst    (rst),
    .load_i (accept),
    .line_i (start_addr_i[ADDR_W-1:OFF_W]),
    .off_i  (eff_off),
    .beat_i (beat_idx_o),
    .addr_o (qw_addr_o)
  );

  always_ff @(posedge clk) begin
    if (rst) err_q <= 1'b0;
    else     err_q <= accept && bad;
  end
  assign err_o = err_q;

  assign inq_addr_o = inq_en_i ? {inq_line_i, {OFF_W{1'b0}}} : '0;

  logic [LINE_W-1:0] unused_line;
  assign unused_line = '0;
endmodule

// File: rtl/burst_qw_seq_chk.sv
module burst_qw_seq_chk #(
  parameter int ADDR_W = 29,
  parameter int OFF_W  = 2,
  parameter int BE_W   = 8
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    start_i,
  input logic [ADDR_W-1:0]       start_addr_i,
  input logic                    wb_i,
  input logic [BE_W-1:0]         be_n_i,
  input logic                    beat_rdy_i,
  input logic                    qw_valid_o,
  input logic [ADDR_W-1:0]       qw_addr_o,
  input logic [OFF_W-1:0]        beat_idx_o,
  input logic                    last_o,
  input logic                    err_o,
  input logic                    inq_en_i,
  input logic [ADDR_W-OFF_W-1:0] inq_line_i,
  input logic [ADDR_W-1:0]       inq_addr_o
);
  // R1
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!qw_valid_o && !last_o && !err_o && beat_idx_o == '0));

  // R2
  a_r2_start_read: assert property (@(posedge clk) disable iff (rst)
    (start_i && !qw_valid_o && !wb_i) |=>
      (qw_valid_o && beat_idx_o == '0 && qw_addr_o == $past(start_addr_i)));

  // R3
  a_r3_interleave: assert property (@(posedge clk) disable iff (rst)
    (qw_valid_o && beat_rdy_i && !last_o) |=>
      (qw_addr_o[ADDR_W-1:OFF_W] == $past(qw_addr_o[ADDR_W-1:OFF_W]) &&
       ((qw_addr_o[OFF_W-1:0] ^ $past(qw_addr_o[OFF_W-1:0])) ==
        (beat_idx_o ^ $past(beat_idx_o)))));

  // R4, R6
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (qw_valid_o && !beat_rdy_i) |=>
      (qw_valid_o && $stable(qw_addr_o) && $stable(beat_idx_o) && $stable(last_o)));

  // R4
  a_r4_advance: assert property (@(posedge clk) disable iff (rst)
    (qw_valid_o && beat_rdy_i && !last_o) |=> (beat_idx_o == $past(beat_idx_o) + 1'b1));

  // R5
  a_r5_end: assert property (@(posedge clk) disable iff (rst)
    (last_o && beat_rdy_i) |=> !qw_valid_o);

  a_r5_last_valid: assert property (@(posedge clk) disable iff (rst)
    last_o |-> qw_valid_o);

  // R8
  a_r8_wb_zero: assert property (@(posedge clk) disable iff (rst)
    (start_i && !qw_valid_o && wb_i) |=> (qw_addr_o[OFF_W-1:0] == '0));

  // R9, R7
  a_r9_err_cause: assert property (@(posedge clk) disable iff (rst)
    (start_i && !qw_valid_o) |=>
      (err_o == ($past(wb_i) && ($past(start_addr_i[OFF_W-1:0]) != '0 ||
                                 $past(be_n_i) != '0))));

  a_r9_err_pulse: assert property (@(posedge clk) disable iff (rst)
    err_o |=> !err_o);

  // R10
  a_r10_inquire: assert property (@(posedge clk) disable iff (rst)
    inq_en_i |-> (inq_addr_o[OFF_W-1:0] == '0 &&
                  inq_addr_o[ADDR_W-1:OFF_W] == inq_line_i));
endmodule

bind burst_qw_seq burst_qw_seq_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .BE_W(BE_W)) u_bqs_chk (.*);

// File: tb/burst_qw_seq_tb_top.sv
module burst_qw_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        start_i;
  logic [28:0] start_addr_i;
  logic        wb_i;
  logic [7:0]  be_n_i;
  logic        beat_rdy_i;
  logic        qw_valid_o;
  logic [28:0] qw_addr_o;
  logic [1:0]  beat_idx_o;
  logic        last_o;
  logic        err_o;
  logic        inq_en_i;
  logic [26:0] inq_line_i;
  logic [28:0] inq_addr_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  burst_qw_seq dut_i (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic do_start(input logic [28:0] a, input logic wb, input logic [7:0] be);
    @(negedge clk);
    start_i = 1'b1; start_addr_i = a; wb_i = wb; be_n_i = be;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0; be_n_i = 8'hFF; wb_i = 1'b0;
  endtask

  // Runs the four beats after a start; present at negedge just after start edge.
  task automatic run_beats(input string tag, input logic [28:0] a, input logic wb,
                           input bit stall);
    logic [1:0] off;
    off = wb ? 2'b00 : a[1:0];
    for (int b = 0; b < 4; b++) begin
      if (stall) begin
        beat_rdy_i = 1'b0;
        @(posedge clk); @(negedge clk);
        chk({tag, " R4 hold addr"}, qw_addr_o, {a[28:2], off ^ b[1:0]});
        chk({tag, " R4 hold beat"}, beat_idx_o, b);
      end
      beat_rdy_i = 1'b1;
      chk({tag, " R3 addr"}, qw_addr_o, {a[28:2], off ^ b[1:0]});
      chk({tag, " R4 beat"}, beat_idx_o, b);
      chk({tag, " R5 last"}, last_o, (b == 3));
      chk({tag, " R2 valid"}, qw_valid_o, 1);
      @(posedge clk); @(negedge clk);
      beat_rdy_i = 1'b0;
    end
    chk({tag, " R5 idle after last"}, qw_valid_o, 0);
  endtask

  task automatic t_reset();
    rst = 1'b1; start_i = 0; start_addr_i = 0; wb_i = 0; be_n_i = 8'hFF;
    beat_rdy_i = 0; inq_en_i = 0; inq_line_i = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 valid", qw_valid_o, 0);
    chk("R1 beat", beat_idx_o, 0);
    chk("R1 err", err_o, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 last after", last_o, 0);
    chk("R1 valid after", qw_valid_o, 0);
  endtask

  task automatic t_reads();
    for (int o = 0; o < 4; o++) begin
      logic [28:0] a;
      a = {27'h2A5_1C3 + 27'(o), 2'(o)};
      do_start(a, 1'b0, 8'h00);
      chk("R2 start addr", qw_addr_o, a);
      chk("R7 no err read", err_o, 0);
      run_beats("read", a, 1'b0, 1'b0);
    end
  endtask

  task automatic t_stall();
    logic [28:0] a;
    a = {27'h555_5555, 2'b10};
    do_start(a, 1'b0, 8'hF0);
    run_beats("stall", a, 1'b0, 1'b1);
  endtask

  task automatic t_sparse_be();
    logic [28:0] a;
    a = {27'h012_3456, 2'b11};
    do_start(a, 1'b0, 8'b1011_0111);
    chk("R7 sparse be no err", err_o, 0);
    run_beats("R7 sparse", a, 1'b0, 1'b0);
  endtask

  task automatic t_ignore_start();
    logic [28:0] a;
    a = {27'h7AB_CDEF, 2'b01};
    do_start(a, 1'b0, 8'h00);
    beat_rdy_i = 1'b1;
    @(posedge clk); @(negedge clk);
    beat_rdy_i = 1'b0;
    start_i = 1'b1; start_addr_i = {27'h111_1111, 2'b11}; wb_i = 1'b1; be_n_i = 8'h55;
    @(posedge clk); @(negedge clk);
    start_i = 1'b0; wb_i = 1'b0; be_n_i = 8'hFF;
    chk("R6 addr kept", qw_addr_o, {a[28:2], 2'b00});
    chk("R6 beat kept", beat_idx_o, 1);
    chk("R6 no err", err_o, 0);
    for (int b = 1; b < 4; b++) begin
      beat_rdy_i = 1'b1;
      chk("R6 rest addr", qw_addr_o, {a[28:2], 2'b01 ^ b[1:0]});
      @(posedge clk); @(negedge clk);
      beat_rdy_i = 1'b0;
    end
    chk("R6 idle after", qw_valid_o, 0);
  endtask

  task automatic t_writeback(input string tag, input logic [28:0] a, input logic [7:0] be,
                             input logic exp_err);
    do_start(a, 1'b1, be);
    chk({tag, " R9 err"}, err_o, exp_err);
    chk({tag, " R8 first off"}, qw_addr_o[1:0], 0);
    @(posedge clk); @(negedge clk);
    chk({tag, " R9 err one cycle"}, err_o, 0);
    run_beats({tag, " R8"}, {a[28:2], 2'b00}, 1'b1, 1'b0);
  endtask

  task automatic t_inquire();
    inq_en_i = 1'b0; inq_line_i = 27'h6DB_6DB6;
    #1;
    chk("R10 off", inq_addr_o, 0);
    inq_en_i = 1'b1;
    #1;
    chk("R10 on", inq_addr_o, {27'h6DB_6DB6, 2'b00});
    inq_line_i = 27'h000_0001;
    #1;
    chk("R10 change", inq_addr_o, 29'h4);
    inq_en_i = 1'b0;
  endtask

  initial begin
    t_reset();
    t_reads();
    t_stall();
    t_sparse_be();
    t_ignore_start();
    t_writeback("wb clean", {27'h3C3_C3C3, 2'b00}, 8'h00, 1'b0);
    t_writeback("wb misal", {27'h3C3_C3C4, 2'b10}, 8'h00, 1'b1);
    t_writeback("wb bytes", {27'h3C3_C3C5, 2'b00}, 8'h0F, 1'b1);
    t_inquire();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=running exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule